// File: doc/BRIEF.md
# Fused Micro-op Reservation Station

This block is a four-slot scheduling buffer for an out-of-order core. Each slot holds one fused micro-op. A fused micro-op is either a store, made of an address part and a data part, or a load-op, made of a load part and a dependent arithmetic part. The whole pair takes one slot when it is allocated and leaves as one unit when it retires. Inside the slot, the two parts are scheduled separately. Each part goes out on its own port as soon as the operands it needs are ready.

An allocation carries the kind of micro-op and three source tags, each with a ready flag. Source 0 is the base register and source 1 is the index register. Source 2 is the store data for a store, or the register operand for a load-op. A tag broadcast marks matching sources as ready. Port A sends address and load parts to the memory unit, and port B sends data and arithmetic parts to the data/ALU unit. Each unit later reports completion by slot index, with a fault flag. Slots retire in allocation order, and each retirement carries any recorded fault.

Top module: `fused_rs`

## Requirements
- R1: After reset, no slot is occupied: `alloc_ready` is 1, and `a_valid`, `b_valid` and `ret_valid` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready`) takes exactly one slot. Slots are handed out in rising index order, with wrap-around. When all four slots are occupied, `alloc_ready` is 0 and `alloc_valid` is ignored.
- R3: A broadcast on `wake_tag` with `wake_valid` sets the ready flag of every matching source in an occupied slot at that clock edge. A source allocated in the same cycle as a matching broadcast is stored as ready. Dispatch that depends on the flag becomes visible in the cycle after the edge.
- R4: For a store (`alloc_is_store`=1), the address part is offered on port A once sources 0 and 1 are ready, whatever the state of source 2. The data part is offered on port B once source 2 is ready. Both parts may be offered in the same cycle.
- R5: For a load-op (`alloc_is_store`=0), the load part is offered on port A once sources 0 and 1 are ready. The arithmetic part is offered on port B only after the load completion has been registered and source 2 is ready.
- R6: A slot retires only after both of its parts have completed. `ret_valid` rises in the cycle after the clock edge that registers the later completion.
- R7: Retirement follows allocation order, at most one slot per cycle. `ret_idx` gives the slot and `ret_is_store` gives its kind.
- R8: Each port offers at most one part per cycle, chosen as the oldest eligible slot. A part is offered for exactly one cycle and never again.
- R9: A fault flag on either completion is stored in the slot. It appears only on `ret_fault`, when that slot retires.
- R10: A synchronous `flush` empties all slots and resets the allocation and retire order to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous clear of all slots |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_store | input | 1 | 1 = store pair, 0 = load-op pair |
| alloc_src_tag | input | 3*TAG_W | Source tags; source s is at bits [s*TAG_W +: TAG_W] |
| alloc_src_rdy | input | 3 | Ready flag for each source |
| alloc_ready | output | 1 | A free slot exists |
| wake_valid | input | 1 | Tag broadcast valid |
| wake_tag | input | TAG_W | Broadcast tag |
| a_valid | output | 1 | Address/load part dispatched |
| a_idx | output | IDX_W | Slot of the port A part |
| a_is_store | output | 1 | Kind of the port A slot |
| b_valid | output | 1 | Data/arithmetic part dispatched |
| b_idx | output | IDX_W | Slot of the port B part |
| b_is_store | output | 1 | Kind of the port B slot |
| a_done_valid | input | 1 | Port A part completed |
| a_done_idx | input | IDX_W | Slot of the port A completion |
| a_done_fault | input | 1 | Port A part faulted |
| b_done_valid | input | 1 | Port B part completed |
| b_done_idx | input | IDX_W | Slot of the port B completion |
| b_done_fault | input | 1 | Port B part faulted |
| ret_valid | output | 1 | Oldest slot retires this cycle |
| ret_idx | output | IDX_W | Retiring slot |
| ret_is_store | output | 1 | Kind of the retiring slot |
| ret_fault | output | 1 | Either part of the retiring slot faulted |

## Verification
Every output is a function of registered state alone. An allocation, a broadcast or a completion therefore shows up on the dispatch, retire and `alloc_ready` outputs exactly one edge later. Chained effects take one edge per link: a load completion is followed a cycle later by the arithmetic dispatch, and the final completion by the retirement. The bench drives inputs and compares at the falling edge. Its model applies each rising edge's inputs in the same order of effects, so every compare lands in the cycle where the result first becomes due.

// File: rtl/fused_rs.sv
module fused_rs #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               alloc_valid,
  input  logic               alloc_is_store,
  input  logic [3*TAG_W-1:0] alloc_src_tag,
  input  logic [2:0]         alloc_src_rdy,
  output logic               alloc_ready,
  input  logic               wake_valid,
  input  logic [TAG_W-1:0]   wake_tag,
  output logic               a_valid,
  output logic [IDX_W-1:0]   a_idx,
  output logic               a_is_store,
  output logic               b_valid,
  output logic [IDX_W-1:0]   b_idx,
  output logic               b_is_store,
  input  logic               a_done_valid,
  input  logic [IDX_W-1:0]   a_done_idx,
  input  logic               a_done_fault,
  input  logic               b_done_valid,
  input  logic [IDX_W-1:0]   b_done_idx,
  input  logic               b_done_fault,
  output logic               ret_valid,
  output logic [IDX_W-1:0]   ret_idx,
  output logic               ret_is_store,
  output logic               ret_fault
);
  logic [ENTRIES-1:0] v, st, a_iss, b_iss, a_dn, b_dn, flt;
  logic [2:0]         rdy [ENTRIES];
  logic [TAG_W-1:0]   tg  [ENTRIES][3];
  logic [IDX_W-1:0]   head, tail;
  logic [IDX_W:0]     cnt;
  logic [ENTRIES-1:0] a_elig, b_elig;
  logic               alloc_fire;

  assign alloc_ready = (cnt != (IDX_W+1)'(ENTRIES));
  assign alloc_fire  = alloc_valid && alloc_ready;

  // port A needs base and index; port B needs source 2, plus a finished load for a load-op
  for (genvar i = 0; i < ENTRIES; i++) begin : g_elig
    assign a_elig[i] = v[i] && !a_iss[i] && rdy[i][0] && rdy[i][1];
    assign b_elig[i] = v[i] && !b_iss[i] && rdy[i][2] && (st[i] || a_dn[i]);
  end

  // scan from youngest to oldest so the oldest eligible slot is the one kept
  always_comb begin
    logic [IDX_W-1:0] j;
    a_valid = 1'b0; a_idx = '0;
    b_valid = 1'b0; b_idx = '0;
    for (int k = ENTRIES-1; k >= 0; k--) begin
      j = head + IDX_W'(k);
      if (a_elig[j]) begin a_valid = 1'b1; a_idx = j; end
      if (b_elig[j]) begin b_valid = 1'b1; b_idx = j; end
    end
  end

  assign a_is_store   = st[a_idx];
  assign b_is_store   = st[b_idx];
  assign ret_valid    = v[head] && a_dn[head] && b_dn[head];
  assign ret_idx      = head;
  assign ret_is_store = st[head];
  assign ret_fault    = flt[head];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      v <= '0; a_iss <= '0; b_iss <= '0; a_dn <= '0; b_dn <= '0; flt <= '0; st <= '0;
      head <= '0; tail <= '0; cnt <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int s = 0; s < 3; s++)
          if (v[i] && wake_valid && tg[i][s] == wake_tag) rdy[i][s] <= 1'b1;
        if (a_valid && a_idx == IDX_W'(i)) a_iss[i] <= 1'b1;
        if (b_valid && b_idx == IDX_W'(i)) b_iss[i] <= 1'b1;
        if (a_done_valid && a_done_idx == IDX_W'(i)) a_dn[i] <= 1'b1;
        if (b_done_valid && b_done_idx == IDX_W'(i)) b_dn[i] <= 1'b1;
        flt[i] <= flt[i]
                | (a_done_valid && a_done_idx == IDX_W'(i) && a_done_fault)
                | (b_done_valid && b_done_idx == IDX_W'(i) && b_done_fault);
        if (ret_valid && head == IDX_W'(i)) v[i] <= 1'b0;
        if (alloc_fire && tail == IDX_W'(i)) begin
          v[i]     <= 1'b1;
          st[i]    <= alloc_is_store;
          a_iss[i] <= 1'b0; b_iss[i] <= 1'b0;
          a_dn[i]  <= 1'b0; b_dn[i]  <= 1'b0;
          flt[i]   <= 1'b0;
          for (int s = 0; s < 3; s++) begin
            tg[i][s]  <= alloc_src_tag[s*TAG_W +: TAG_W];
            rdy[i][s] <= alloc_src_rdy[s]
                       | (wake_valid && alloc_src_tag[s*TAG_W +: TAG_W] == wake_tag);
          end
        end
      end
      if (alloc_fire) tail <= tail + 1'b1;
      if (ret_valid)  head <= head + 1'b1;
      cnt <= cnt + (IDX_W+1)'(alloc_fire) - (IDX_W+1)'(ret_valid);
    end
  end
endmodule

module fused_rs_chk #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             a_valid,
  input logic [IDX_W-1:0] a_idx,
  input logic             b_valid,
  input logic [IDX_W-1:0] b_idx,
  input logic             b_is_store,
  input logic             a_done_valid,
  input logic [IDX_W-1:0] a_done_idx,
  input logic             b_done_valid,
  input logic [IDX_W-1:0] b_done_idx,
  input logic             ret_valid,
  input logic [IDX_W-1:0] ret_idx
);
  logic [IDX_W:0]     occ;
  logic [IDX_W-1:0]   nxt_ret;
  logic [ENTRIES-1:0] seen_a, seen_b;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      occ <= '0; nxt_ret <= '0; seen_a <= '0; seen_b <= '0;
    end else begin
      occ <= occ + (IDX_W+1)'(alloc_valid && alloc_ready) - (IDX_W+1)'(ret_valid);
      if (ret_valid) begin
        nxt_ret <= nxt_ret + 1'b1;
        seen_a[ret_idx] <= 1'b0;
        seen_b[ret_idx] <= 1'b0;
      end
      if (a_done_valid) seen_a[a_done_idx] <= 1'b1;
      if (b_done_valid) seen_b[b_done_idx] <= 1'b1;
    end
  end

  p_free_slot_r2:   assert property (@(posedge clk) disable iff (!rst_n)
                      alloc_ready |-> occ < (IDX_W+1)'(ENTRIES));
  p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
                      !alloc_ready |-> occ == (IDX_W+1)'(ENTRIES));
  p_op_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
                      (b_valid && !b_is_store) |-> seen_a[b_idx]);
  p_both_done_r6:   assert property (@(posedge clk) disable iff (!rst_n)
                      ret_valid |-> (seen_a[ret_idx] && seen_b[ret_idx]));
  p_in_order_r7:    assert property (@(posedge clk) disable iff (!rst_n)
                      ret_valid |-> ret_idx == nxt_ret);
  p_a_once_r8:      assert property (@(posedge clk) disable iff (!rst_n)
                      (a_valid && !flush) |=> !(a_valid && a_idx == $past(a_idx)));
  p_b_once_r8:      assert property (@(posedge clk) disable iff (!rst_n)
                      (b_valid && !flush) |=> !(b_valid && b_idx == $past(b_idx)));
endmodule

bind fused_rs fused_rs_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/test_fused_rs.sv
module test_fused_rs;
  localparam int ENT = 4;
  localparam int TW  = 6;
  localparam int IW  = 2;

  logic clk = 0, rst_n = 0, flush = 0;
  logic alloc_valid = 0, alloc_is_store = 0;
  logic [3*TW-1:0] alloc_src_tag = '0;
  logic [2:0] alloc_src_rdy = '0;
  logic alloc_ready;
  logic wake_valid = 0;
  logic [TW-1:0] wake_tag = '0;
  logic a_valid, a_is_store, b_valid, b_is_store;
  logic [IW-1:0] a_idx, b_idx, ret_idx;
  logic a_done_valid = 0, a_done_fault = 0, b_done_valid = 0, b_done_fault = 0;
  logic [IW-1:0] a_done_idx = '0, b_done_idx = '0;
  logic ret_valid, ret_is_store, ret_fault;

  fused_rs #(.ENTRIES(ENT), .TAG_W(TW)) i_fused_rs (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, resp_pct = 100;
  bit fa_plan = 0, fb_plan = 0, finished = 0;

  // reference model: slots by index, age order kept in a queue
  int age[$];
  int pa[$], pb[$];
  bit mv[ENT], mst[ENT], mai[ENT], mbi[ENT], mad[ENT], mbd[ENT], mf[ENT], mfa[ENT], mfb[ENT];
  bit mr[ENT][3];
  int mtag[ENT][3];
  int tailp = 0;

  function automatic int pick_a();
    foreach (age[k]) if (!mai[age[k]] && mr[age[k]][0] && mr[age[k]][1]) return age[k];
    return -1;
  endfunction
  function automatic int pick_b();
    foreach (age[k]) if (!mbi[age[k]] && mr[age[k]][2] && (mst[age[k]] || mad[age[k]])) return age[k];
    return -1;
  endfunction
  function automatic bit can_ret();
    return age.size() > 0 && mad[age[0]] && mbd[age[0]];
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || flush) begin
      age = {}; pa = {}; pb = {}; tailp = 0;
      foreach (mv[i]) mv[i] = 0;
    end else begin
      int ea, eb, idx;
      bit er, room;
      ea = pick_a(); eb = pick_b(); er = can_ret(); room = age.size() < ENT;
      foreach (age[k]) for (int s = 0; s < 3; s++)
        if (wake_valid && mtag[age[k]][s] == int'(wake_tag)) mr[age[k]][s] = 1;
      if (ea >= 0) begin mai[ea] = 1; pa.push_back(ea); end
      if (eb >= 0) begin mbi[eb] = 1; pb.push_back(eb); end
      if (a_done_valid) begin mad[a_done_idx] = 1; if (a_done_fault) mf[a_done_idx] = 1; end
      if (b_done_valid) begin mbd[b_done_idx] = 1; if (b_done_fault) mf[b_done_idx] = 1; end
      if (er) begin mv[age[0]] = 0; void'(age.pop_front()); end
      if (alloc_valid && room) begin
        idx = tailp; tailp = (tailp + 1) % ENT;
        age.push_back(idx);
        mv[idx] = 1; mst[idx] = alloc_is_store;
        mai[idx] = 0; mbi[idx] = 0; mad[idx] = 0; mbd[idx] = 0; mf[idx] = 0;
        mfa[idx] = fa_plan; mfb[idx] = fb_plan;
        for (int s = 0; s < 3; s++) begin
          mtag[idx][s] = int'(alloc_src_tag[s*TW +: TW]);
          mr[idx][s] = alloc_src_rdy[s] || (wake_valid && alloc_src_tag[s*TW +: TW] == wake_tag);
        end
      end
    end
  end

  // completion responder for dispatched parts
  always @(negedge clk) begin
    a_done_valid = 0; b_done_valid = 0;
    if (pa.size() > 0 && int'($urandom % 100) < resp_pct) begin
      a_done_idx = IW'(pa[0]); a_done_fault = mfa[pa[0]]; a_done_valid = 1; void'(pa.pop_front());
    end
    if (pb.size() > 0 && int'($urandom % 100) < resp_pct) begin
      b_done_idx = IW'(pb[0]); b_done_fault = mfb[pb[0]]; b_done_valid = 1; void'(pb.pop_front());
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !finished) begin
    int ea, eb;
    ea = pick_a(); eb = pick_b();
    check("R2 alloc_ready", alloc_ready, age.size() < ENT);
    check("R4 R5 R8 a_valid", a_valid, ea >= 0);
    if (ea >= 0) begin
      check("R8 a_idx", a_idx, ea);
      check("R4 a_is_store", a_is_store, mst[ea]);
    end
    check("R3 R5 R8 b_valid", b_valid, eb >= 0);
    if (eb >= 0) begin
      check("R8 b_idx", b_idx, eb);
      check("R5 b_is_store", b_is_store, mst[eb]);
    end
    check("R6 R7 ret_valid", ret_valid, can_ret());
    if (can_ret()) begin
      check("R7 ret_idx", ret_idx, age[0]);
      check("R7 ret_is_store", ret_is_store, mst[age[0]]);
      check("R9 ret_fault", ret_fault, mf[age[0]]);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic alloc(bit is_st, int t0, int t1, int t2, bit [2:0] r, bit fa = 0, bit fb = 0);
    alloc_valid = 1; alloc_is_store = is_st;
    alloc_src_tag = {TW'(t2), TW'(t1), TW'(t0)}; alloc_src_rdy = r;
    fa_plan = fa; fb_plan = fb;
    step();
    alloc_valid = 0;
  endtask

  task automatic wake(int t);
    wake_valid = 1; wake_tag = TW'(t);
    step();
    wake_valid = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1: empty after reset
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 a_valid", a_valid, 0);
    check("R1 b_valid", b_valid, 0);
    check("R1 ret_valid", ret_valid, 0);

    // R4: store whose data is not ready yet, then woken
    alloc(1, 1, 2, 3, 3'b011);
    check("R4 address part without data", a_valid, 1);
    check("R4 data part waits", b_valid, 0);
    step(2);
    wake(3);
    check("R3 R4 data part after wake", b_valid, 1);
    step(4);

    // R5: load-op, arithmetic part must wait for the load completion
    alloc(0, 4, 5, 6, 3'b111);
    check("R5 load dispatched", a_valid, 1);
    check("R5 op held", b_valid, 0);
    step(6);

    // R9: faults on each kind of part
    alloc(1, 0, 0, 0, 3'b111, 1, 0);
    alloc(0, 0, 0, 0, 3'b111, 0, 1);
    step(8);

    // R2: fill all slots, then try one more
    resp_pct = 100;
    for (int n = 0; n < ENT; n++) alloc(n % 2, 10, 10, 10, 3'b000);
    check("R2 full", alloc_ready, 0);
    alloc(1, 11, 11, 11, 3'b111);
    check("R2 still full", alloc_ready, 0);
    wake(10);
    step(12);

    // R3: allocation and matching broadcast in one cycle
    wake_valid = 1; wake_tag = 20;
    alloc(1, 20, 21, 22, 3'b010);
    wake_valid = 0;
    check("R3 same-cycle capture", a_valid, 1);
    wake(22);
    step(6);

    // R10: flush with waiting slots
    alloc(0, 30, 31, 32, 3'b000);
    alloc(1, 30, 31, 32, 3'b000);
    flush = 1; step(); flush = 0;
    check("R10 alloc_ready", alloc_ready, 1);
    check("R10 ret_valid", ret_valid, 0);
    check("R10 a_valid", a_valid, 0);
    alloc(1, 40, 41, 42, 3'b111);
    check("R10 restart at slot 0", a_idx, 0);
    step(6);

    // mixed traffic
    resp_pct = 60;
    for (int c = 0; c < 4000; c++) begin
      alloc_valid = ($urandom % 3) == 0;
      alloc_is_store = $urandom % 2;
      alloc_src_tag = {TW'($urandom % 8), TW'($urandom % 8), TW'($urandom % 8)};
      alloc_src_rdy = 3'($urandom);
      fa_plan = ($urandom % 8) == 0; fb_plan = ($urandom % 8) == 0;
      wake_valid = $urandom % 2; wake_tag = TW'($urandom % 8);
      flush = ($urandom % 250) == 0;
      step();
    end
    alloc_valid = 0; flush = 0; wake_valid = 0;
    step(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule